// File: doc/BRIEF.md
# Machine-Cycle-Phased Falling-Edge Detector

This block watches one asynchronous input pin for a high-to-low transition and turns each one into a single-clock event strobe. The strobe lands at a fixed point of a 12-clock machine cycle. A free-running phase counter splits the machine cycle into six states of two oscillator clocks each. A detected edge goes through three steps. A first-stage latch records it. A second stage takes it over only on the first clock of a chosen transfer state. The strobe is released on the first clock of a chosen release state.

The transfer state and the release state are parameters, so the same block serves two inputs. With transfer state 5 and release state 3 it is the external counting-clock input of a timer. With transfer state 2 and release state 4 it is the external capture/reload flag input. The logic that consumes the strobe sits outside this block. The pin is only guaranteed to be seen if it stays low for at least 12 oscillator clocks and high for at least 12.

Top module: `mc_fall_detect`

## Requirements
- R1: The phase counter counts 0 to 11 and wraps to 0. It is 0 on the clock edge that ends reset. After n clock edges following reset release, its value is n mod 12. State s (1 to 6) covers counts 2(s-1) and 2(s-1)+1.
- R2: The pin passes through a two-flop synchronizer. If the pin is first sampled low on clock edge n after being sampled high, the first-stage latch is set from the cycle after edge n+1 onward, so it is visible in cycle n+2.
- R3: A set first-stage latch is moved into the second stage only in a cycle where the counter equals 2(XFER_STATE-1). That count is 8 for the default of 5 and 2 for the flag variant's 2.
- R4: `event_o` is high for exactly one clock. It goes high in the first cycle after the transfer in which the counter equals 2(REL_STATE-1), which is 4 for the default of 3 and 6 for the flag variant's 4. The second stage is then empty.
- R5: A low-to-high change of the pin produces no strobe.
- R6: The first-stage latch clears when the second stage takes the event. A later falling edge then produces its own separate strobe.
- R7: A falling edge that arrives while the first-stage latch is still set merges into the pending event. Only one strobe results.
- R8: A synchronous reset held for at least 3 clocks empties both stages and zeroes the counter. A strobe pending at reset is dropped. A pin that is already low when reset ends does not count as an edge.
- R9: Illegal parameters stop elaboration. These are: transfer state equal to release state, either state outside 1..6, a cycle length other than states times clocks per state, or fewer than 2 synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pin_i | input | 1 | Asynchronous external pin |
| event_o | output | 1 | One-clock event strobe at the release state |

## Verification
The hardest case to reach is the merge of a second falling edge into an event that is still waiting in the first stage. The pin has to fall, rise and fall again in fewer clocks than the time left before the next transfer state. The bench builds this by breaking the minimum-width rule on purpose. It times the first fall just after the transfer state and toggles the pin every two clocks. In every test the bench computes the expected strobe cycle from the phase at which it drove the fall. It runs two instances that use different transfer and release states.

// File: rtl/mcfd_pkg.sv
package mcfd_pkg;
   localparam int unsigned MCFD_STATES          = 6;
   localparam int unsigned MCFD_CLKS_PER_STATE  = 2;
   localparam int unsigned MCFD_CYCLE_CLKS      = MCFD_STATES * MCFD_CLKS_PER_STATE;

   // first counter value of a 1-based state
   function automatic int unsigned state_first_count(input int unsigned st,
                                                     input int unsigned clks_per_state);
      return (st - 1) * clks_per_state;
   endfunction
endpackage

// File: rtl/mcfd_phase_gen.sv
module mcfd_phase_gen #(
   parameter int unsigned CYCLE_CLKS = 12,
   parameter int unsigned XFER_COUNT = 8,
   parameter int unsigned REL_COUNT  = 4,
   localparam int unsigned CNT_W     = $clog2(CYCLE_CLKS)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             xfer_tick_o,
   output logic             rel_tick_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)              cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o       = cnt_q;
   assign xfer_tick_o = (cnt_q == CNT_W'(XFER_COUNT));
   assign rel_tick_o  = (cnt_q == CNT_W'(REL_COUNT));

   // R1: wrap at the end of the machine cycle
   a_r1_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q == LAST) |=> (cnt_q == '0));
   // R1: counter stays in range
   a_r1_range: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST);
endmodule

// File: rtl/mcfd_sync.sv
module mcfd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic pin_i,
   output logic level_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk_i) chain_q[0] <= pin_i;
         end else begin : g_body
            always_ff @(posedge clk_i) chain_q[gi] <= chain_q[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk_i) prev_q <= chain_q[STAGES-1];

   assign level_o = chain_q[STAGES-1];
   assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/mcfd_edge_stage.sv
module mcfd_edge_stage (
   input  logic clk_i,
   input  logic rst_i,
   input  logic fall_i,
   input  logic xfer_tick_i,
   input  logic rel_tick_i,
   output logic latch_o,
   output logic held_o,
   output logic strobe_o
);
   logic latch_q, held_q, take;

   assign take = xfer_tick_i & latch_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         latch_q <= 1'b0;
         held_q  <= 1'b0;
      end else begin
         latch_q <= fall_i | (latch_q & ~take);
         if (take)            held_q <= 1'b1;
         else if (rel_tick_i) held_q <= 1'b0;
      end
   end

   assign strobe_o = held_q & rel_tick_i;
   assign latch_o  = latch_q;
   assign held_o   = held_q;

   // R6: the first stage only empties into the second stage at a transfer tick
   a_r6_latch_clears_on_take: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(latch_q) |-> $past(xfer_tick_i));
   // R4: strobe lasts a single clock
   a_r4_single_clock: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |=> !strobe_o);
   // R4: second stage is empty after its strobe
   a_r4_held_empties: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |=> !held_q);
endmodule

// File: rtl/mc_fall_detect.sv
module mc_fall_detect #(
   parameter int unsigned STATES         = mcfd_pkg::MCFD_STATES,
   parameter int unsigned CLKS_PER_STATE = mcfd_pkg::MCFD_CLKS_PER_STATE,
   parameter int unsigned CYCLE_CLKS     = mcfd_pkg::MCFD_CYCLE_CLKS,
   parameter int unsigned XFER_STATE     = 5,
   parameter int unsigned REL_STATE      = 3,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic pin_i,
   output logic event_o
);
   localparam int unsigned XFER_COUNT = mcfd_pkg::state_first_count(XFER_STATE, CLKS_PER_STATE);
   localparam int unsigned REL_COUNT  = mcfd_pkg::state_first_count(REL_STATE, CLKS_PER_STATE);
   localparam int unsigned CNT_W      = $clog2(CYCLE_CLKS);

   // R9: elaboration-time parameter checks
   generate
      if (CYCLE_CLKS != STATES * CLKS_PER_STATE) begin : g_bad_cycle
         $error("cycle length must equal states times clocks per state");
      end
      if (XFER_STATE == REL_STATE) begin : g_bad_same
         $error("transfer and release states must differ");
      end
      if (XFER_STATE < 1 || XFER_STATE > STATES || REL_STATE < 1 || REL_STATE > STATES) begin : g_bad_range
         $error("state parameter out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs at least two stages");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic xfer_tick, rel_tick, fall, level, latch, held;

   mcfd_phase_gen #(
      .CYCLE_CLKS (CYCLE_CLKS),
      .XFER_COUNT (XFER_COUNT),
      .REL_COUNT  (REL_COUNT)
   ) u_phase (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .cnt_o       (cnt),
      .xfer_tick_o (xfer_tick),
      .rel_tick_o  (rel_tick)
   );

   mcfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .pin_i   (pin_i),
      .level_o (level),
      .fall_o  (fall)
   );

   mcfd_edge_stage u_stage (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .fall_i      (fall),
      .xfer_tick_i (xfer_tick),
      .rel_tick_i  (rel_tick),
      .latch_o     (latch),
      .held_o      (held),
      .strobe_o    (event_o)
   );

   // R3: second stage is loaded only at the transfer count
   a_r3_take_at_xfer: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(held) |-> ($past(cnt) == CNT_W'(XFER_COUNT)));
   // R4: strobe only at the release count
   a_r4_strobe_at_rel: assert property (@(posedge clk_i) disable iff (rst_i)
      event_o |-> (cnt == CNT_W'(REL_COUNT)));
   // R2: latch is set only after the synchronized level was low
   a_r2_set_after_low: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(latch) |-> !$past(level));
endmodule

// File: tb/tb_mc_fall_detect.sv
module tb_mc_fall_detect;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pin = 1'b1;
   logic ev_t, ev_f;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int cnt_t  = 0, cnt_f = 0;
   int last_t = -1, last_f = -1;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mc_fall_detect dut (.clk_i(clk), .rst_i(rst), .pin_i(pin), .event_o(ev_t));
   mc_fall_detect #(.XFER_STATE(2), .REL_STATE(4)) dut_flag
      (.clk_i(clk), .rst_i(rst), .pin_i(pin), .event_o(ev_f));

   // R1: bench's own count of edges since reset release
   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (ev_t) begin cnt_t++; last_t = cyc; end
      if (ev_f) begin cnt_f++; last_f = cyc; end
   end

   // R2/R3/R4: pin driven low at negedge of cycle c -> expected strobe cycle
   function automatic int exp_cycle(input int c, input int xf, input int rl);
      int k, j;
      k = c + 3;
      while (k % 12 != xf) k++;
      j = k + 1;
      while (j % 12 != rl) j++;
      return j;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_phase(input int p);
      @(negedge clk);
      while (cyc % 12 != p) @(negedge clk);
   endtask

   // {phase of fall, low width}
   localparam int NV = 12;
   localparam int VEC [NV][2] = '{
      '{0, 12}, '{1, 13}, '{2, 12}, '{3, 20}, '{4, 12}, '{5, 14},
      '{6, 12}, '{7, 15}, '{8, 12}, '{9, 30}, '{10, 12}, '{11, 16}};

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails + 0);
      $finish;
   end

   initial begin
      int c, s_t, s_f;
      repeat (4) @(negedge clk);
      check("R8 reset strobe dut", int'(ev_t), 0);
      check("R8 reset strobe dut_flag", int'(ev_f), 0);
      rst = 1'b0;
      repeat (30) @(negedge clk);
      check("R8 no strobe idle dut", cnt_t, 0);
      check("R8 no strobe idle dut_flag", cnt_f, 0);

      // vector table: R1 R2 R3 R4 R5 R6 (edges back to back)
      for (int v = 0; v < NV; v++) begin
         wait_phase(VEC[v][0]);
         s_t = cnt_t; s_f = cnt_f;
         pin = 1'b0; c = cyc;
         repeat (VEC[v][1]) @(negedge clk);
         pin = 1'b1;  // R5: rise must add nothing
         repeat (36) @(negedge clk);
         check("R4 R5 R6 count dut", cnt_t - s_t, 1);
         check("R1 R3 R4 time dut", last_t, exp_cycle(c, 8, 4));
         check("R4 R5 R6 count dut_flag", cnt_f - s_f, 1);
         check("R1 R3 R4 time dut_flag", last_f, exp_cycle(c, 2, 6));
      end

      // R7: merge of a second fall into a pending event
      wait_phase(7);
      s_t = cnt_t; s_f = cnt_f;
      pin = 1'b0; c = cyc;
      repeat (2) @(negedge clk); pin = 1'b1;
      repeat (2) @(negedge clk); pin = 1'b0;
      repeat (14) @(negedge clk); pin = 1'b1;
      repeat (36) @(negedge clk);
      check("R7 merged count dut", cnt_t - s_t, 1);
      check("R7 merged time dut", last_t, exp_cycle(c, 8, 4));
      check("R7 merged count dut_flag", cnt_f - s_f, 1);
      check("R7 merged time dut_flag", last_f, exp_cycle(c, 2, 6));

      // R8: reset drops a pending event; low pin at release is no edge
      wait_phase(5);
      s_t = cnt_t; s_f = cnt_f;
      pin = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 strobe in reset dut", int'(ev_t), 0);
      rst = 1'b0;
      repeat (30) @(negedge clk);
      pin = 1'b1;
      repeat (30) @(negedge clk);
      check("R8 dropped dut", cnt_t - s_t, 0);
      check("R8 dropped dut_flag", cnt_f - s_f, 0);

      // R1 R8: phase restarts after reset
      wait_phase(3);
      s_t = cnt_t; s_f = cnt_f;
      pin = 1'b0; c = cyc;
      repeat (12) @(negedge clk); pin = 1'b1;
      repeat (36) @(negedge clk);
      check("R1 R8 after reset count dut", cnt_t - s_t, 1);
      check("R1 R8 after reset time dut", last_t, exp_cycle(c, 8, 4));
      check("R1 R8 after reset time dut_flag", last_f, exp_cycle(c, 2, 6));

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule